// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers one-cycle event pulses from an I2C transfer engine into a sticky pending register and combines them with an enable mask into one level interrupt line. Software reads the pending bits, then acknowledges them by writing ones back to the pending register. Writing zero to a pending bit leaves it unchanged, so software can write back exactly the value it read.

The mask cannot be written directly. One write-only register sets mask bits and another clears them. Each write therefore changes only the sources it names, and no read-modify-write of the mask is needed.

All four registers use the same event bit map:

| Bit | Event |
|-----|-------|
| 0 | transfer complete |
| 1 | data threshold |
| 2 | NACK |
| 3 | timeout |
| 4 | slave ready |
| 5 | receive overflow |
| 6 | transmit overflow |
| 7 | receive underflow |
| 8 | reserved |
| 9 | arbitration lost |

The register port has a 2-bit address:

| Address | Register |
|---------|----------|
| 0 | pending |
| 1 | mask view |
| 2 | mask set |
| 3 | mask clear |

Top module: `irq_stat_unit`

## Requirements
- R1: After reset, pending and mask read as zero and `irqOut` is low.
- R2: A 1 on `evIn[i]` during a clock edge sets pending bit i, which then holds through later cycles with no event.
- R3: A write to address 0 clears each pending bit whose `wrData` bit is 1. Pending bits whose `wrData` bit is 0 are unchanged.
- R4: When an event pulse and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 2 sets each mask bit whose `wrData` bit is 1. Mask bits whose `wrData` bit is 0 are unchanged. The mask reads back at address 1.
- R6: A write to address 3 clears each mask bit whose `wrData` bit is 1. Writing 0x3FF there clears the whole mask.
- R7: Reads of address 2 and address 3 return zero.
- R8: `irqOut` is high exactly while some bit is set in both pending and mask.
- R9: Bit 8 is reserved. It never becomes set in pending or in mask, whatever events or writes arrive, and it reads as zero.
- R10: A write to address 1 changes nothing. The mask is read-only at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address, used for both reads and writes |
| wrData | input | 10 | Write data |
| rdData | output | 10 | Read data for `regAddr`, combinational |
| evIn | input | 10 | Event pulses, one bit per source |
| irqOut | output | 1 | Level interrupt |

## Verification
The assertions take a write in a given cycle to be the only register access in that cycle. They also take the clear check to apply only in cycles with no event pulse, so that set-over-clear does not muddy it. They rely on events coming in as ordinary bit vectors that may include the reserved bit. The stimulus issues at most one write per cycle from a single driver task, holds `evIn` at zero during read-back cycles, and drives the reserved bit on purpose to check that it is ignored.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  parameter int EV_W   = 10;
  parameter int ADDR_W = 2;
  // Implemented sources; bit 8 is reserved.
  parameter logic [EV_W-1:0] IMPL_MASK = 10'h2FF;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PEND = 2'd0,
    ADDR_VIEW = 2'd1,
    ADDR_SET  = 2'd2,
    ADDR_CLR  = 2'd3
  } regAddrE;

  typedef struct packed {
    logic            clrPend;
    logic            setMask;
    logic            clrMask;
    logic [EV_W-1:0] wData;
  } strobeT;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EV_W-1:0]   wrData,
  output strobeT            strb
);
  always_comb begin
    strb         = '0;
    strb.wData   = wrData & IMPL_MASK;
    strb.clrPend = wrEn && (regAddr == ADDR_PEND);
    strb.setMask = wrEn && (regAddr == ADDR_SET);
    strb.clrMask = wrEn && (regAddr == ADDR_CLR);
  end
endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [EV_W-1:0]   evIn,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [EV_W-1:0]   statQ,
  output logic [EV_W-1:0]   maskQ,
  output logic [EV_W-1:0]   rdData,
  output logic              irqOut
);
  logic [EV_W-1:0] clrBits;
  logic [EV_W-1:0] statNext;
  logic [EV_W-1:0] maskNext;

  always_comb begin
    clrBits  = strb.clrPend ? strb.wData : '0;
    // Set has priority over clear.
    statNext = ((statQ & ~clrBits) | evIn) & IMPL_MASK;
    maskNext = maskQ;
    if (strb.setMask) maskNext = maskNext | strb.wData;
    if (strb.clrMask) maskNext = maskNext & ~strb.wData;
    maskNext = maskNext & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      maskQ <= '0;
    end else begin
      statQ <= statNext;
      maskQ <= maskNext;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_PEND: rdData = statQ;
      ADDR_VIEW: rdData = maskQ;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = |(statQ & maskQ);
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [EV_W-1:0]   wrData,
  output logic [EV_W-1:0]   rdData,
  input  logic [EV_W-1:0]   evIn,
  output logic              irqOut
);
  strobeT          strb;
  logic [EV_W-1:0] statQ;
  logic [EV_W-1:0] maskQ;

  irq_stat_ctrl uCtrl (
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .strb(strb)
  );

  irq_stat_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .evIn(evIn), .regAddr(regAddr),
    .statQ(statQ), .maskQ(maskQ), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk
  import irq_stat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [EV_W-1:0]   wrData,
  input logic [EV_W-1:0]   evIn,
  input logic [EV_W-1:0]   rdData,
  input logic [EV_W-1:0]   statQ,
  input logic [EV_W-1:0]   maskQ
);
  // R2
  ev_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(evIn & IMPL_MASK)) |=> ((statQ & $past(evIn & IMPL_MASK)) == $past(evIn & IMPL_MASK)));
  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd0 && evIn == '0) |=> ((statQ & $past(wrData)) == '0));
  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd2) |=> ((maskQ & $past(wrData & IMPL_MASK)) == $past(wrData & IMPL_MASK)));
  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd3) |=> ((maskQ & $past(wrData)) == '0));
  // R7
  wo_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1]) |-> (rdData == '0));
  // R9
  rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[8] == 1'b0) && (maskQ[8] == 1'b0));
  // R10
  view_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == 2'd1) |=> $stable(maskQ));
endmodule

bind irq_stat_unit irq_stat_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .evIn(evIn), .rdData(rdData), .statQ(statQ), .maskQ(maskQ)
);

// File: tb/sim_irq_stat_unit.sv
`timescale 1ns/1ps
module sim_irq_stat_unit;
  localparam logic [9:0] IMPL = 10'h2FF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [9:0] wrData = '0;
  logic [9:0] evIn = '0;
  logic [9:0] rdData;
  logic       irqOut;
  logic       sampleReq = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [9:0] data;
    logic       irq;
    string      tag;
  } expT;
  expT expQ[$];

  logic [9:0] statM = '0;
  logic [9:0] maskM = '0;

  always #10 clk = ~clk;

  irq_stat_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .evIn(evIn), .irqOut(irqOut)
  );

  task automatic doOp(input logic wr, input logic [1:0] a, input logic [9:0] d,
                      input logic [9:0] ev);
    logic [9:0] clr;
    @(negedge clk);
    sampleReq = 1'b0;
    wrEn = wr; regAddr = a; wrData = d; evIn = ev;
    clr = (wr && a == 2'd0) ? d : '0;
    statM = ((statM & ~clr) | ev) & IMPL;
    if (wr && a == 2'd2) maskM = (maskM | d) & IMPL;
    if (wr && a == 2'd3) maskM = maskM & ~d;
  endtask

  task automatic chk(input logic [1:0] a, input string tag);
    expT e;
    @(negedge clk);
    wrEn = 1'b0; regAddr = a; wrData = '0; evIn = '0;
    e.data = (a == 2'd0) ? statM : (a == 2'd1) ? maskM : 10'h000;
    e.irq  = |(statM & maskM);
    e.tag  = tag;
    expQ.push_back(e);
    sampleReq = 1'b1;
  endtask

  always @(negedge clk) begin
    #5;
    if (sampleReq && expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (rdData !== e.data || irqOut !== e.irq) begin
        errors++;
        $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                 e.tag, rdData, irqOut, e.data, e.irq);
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(2'd0, "R1");
    chk(2'd1, "R1");
    doOp(1'b0, 2'd0, 10'h000, 10'h001);
    chk(2'd0, "R2");
    doOp(1'b0, 2'd0, 10'h000, 10'h000);
    chk(2'd0, "R2");
    doOp(1'b1, 2'd2, 10'h003, 10'h000);
    chk(2'd1, "R5");
    chk(2'd2, "R7");
    chk(2'd0, "R8");
    doOp(1'b1, 2'd0, 10'h002, 10'h000);
    chk(2'd0, "R3");
    doOp(1'b1, 2'd0, 10'h001, 10'h000);
    chk(2'd0, "R3");
    doOp(1'b0, 2'd0, 10'h000, 10'h3FF);
    chk(2'd0, "R9");
    doOp(1'b1, 2'd0, 10'h3FF, 10'h020);
    chk(2'd0, "R4");
    doOp(1'b1, 2'd2, 10'h3FF, 10'h000);
    chk(2'd1, "R9");
    chk(2'd3, "R7");
    doOp(1'b1, 2'd1, 10'h000, 10'h000);
    chk(2'd1, "R10");
    doOp(1'b1, 2'd3, 10'h003, 10'h000);
    chk(2'd1, "R6");
    doOp(1'b1, 2'd3, 10'h3FF, 10'h000);
    chk(2'd1, "R6");
    chk(2'd0, "R8");
    doOp(1'b1, 2'd2, 10'h200, 10'h000);
    chk(2'd0, "R8");
    doOp(1'b1, 2'd2, 10'h020, 10'h000);
    chk(2'd0, "R8");
    doOp(1'b0, 2'd0, 10'h000, 10'h000);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule